// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a two's-complement stereo bit stream into parallel 20-bit left and right samples. A bit clock, a left/right word clock and a serial data line come in from an external source. All three are oversampled by the faster system clock, synchronised, and their edges are found inside the block. A 2-bit format select picks one of four framings. The framings differ in three ways: which bit-clock edge captures data, which word-clock level marks the left channel, and whether a word is anchored at the start or at the end of its half-frame.

A half-frame is the run of bit-clock periods between two word-clock transitions. The word collected during a half-frame is committed at the first sampling edge of the next half-frame, to the channel that the old word-clock level named. When a right word is committed and a left word from the same frame is already held, the pair is presented on the outputs with a one-cycle strobe. A short right-justified word is widened to 20 bits by sign extension. Changing the format select drops everything in flight and aligns again to the word clock.

Top module: `sar_rx`

## Requirements
- R1: Format code 00 (right-justified, 16 bit) captures on the rising bit-clock edge. The word is the last 16 bits sampled before the word-clock transition that ends the half-frame. It is sign-extended to 20 bits by copying bit 15 into bits 19..16.
- R2: Format code 01 (right-justified, 20 bit) captures on the rising bit-clock edge. The word is the last 20 bits sampled before the closing word-clock transition. Bits sampled earlier in the same half-frame have no effect on the output.
- R3: Format code 10 (left-justified, 20 bit) captures on the falling bit-clock edge. The bit at the first falling edge after a word-clock transition is the MSB of a 20-bit word. Every bit after the 20th in that half-frame is ignored.
- R4: Format code 11 (I2S-style, 20 bit) captures on the rising bit-clock edge. The bit at the first rising edge after a word-clock transition is ignored, and the next 20 bits form the word, MSB first. Word clock low marks the left channel.
- R5: For format codes 00, 01 and 10, word clock high marks the left channel and word clock low marks the right channel.
- R6: `valid_o` is high for exactly one system clock each time a right word is committed after a left word of the same frame. `left_o` and `right_o` change only in that cycle and hold their values in every other cycle.
- R7: During and right after reset, `left_o` and `right_o` are zero and `valid_o` is low. The half-frame in progress when the word clock is first observed is discarded. The first pair reported is the frame whose left half begins at the first observed word-clock transition or later.
- R8: A change of the format select discards any partly received word and any held left word, and the block aligns again. No strobe appears until a complete left-then-right pair has been received under the new format, with the same discard rule as R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous to clk |
| wclk_i | input | 1 | Left/right word clock, asynchronous to clk |
| sdata_i | input | 1 | Serial data, MSB first, two's complement |
| fmt_i | input | 2 | Format select: 00 RJ16, 01 RJ20, 10 LJ20, 11 I2S-style 20 |
| left_o | output | 20 | Left sample of the last completed frame |
| right_o | output | 20 | Right sample of the last completed frame |
| valid_o | output | 1 | One-cycle strobe when a new left/right pair is presented |

## Verification
The assertions assume the following about the inputs. Each bit-clock phase lasts at least three system clocks, so the synchroniser sees every level. The word clock and data change only on the bit-clock edge opposite the capturing edge. Every half-frame holds at least 21 bit-clock periods. The format select is treated as static, and any change to it is a deliberate resynchronisation. The bench transmitter holds each bit-clock phase for four system clocks and sends 32-bit half-frames. It moves the word clock and data only on the non-capturing edge. It changes the format only between streams, or in one deliberate mid-frame switch.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int unsigned SAR_WORD_W  = 20;
  localparam int unsigned SAR_SHORT_W = 16;

  typedef enum logic [1:0] {
    FMT_RJ16  = 2'b00,
    FMT_RJ20  = 2'b01,
    FMT_LJ20  = 2'b10,
    FMT_I2S20 = 2'b11
  } sar_fmt_e;

  // Capture happens on the falling bit-clock edge only in left-justified mode.
  function automatic logic sar_on_fall(sar_fmt_e f);
    return f == FMT_LJ20;
  endfunction

  // Word-clock level to channel: inverted for the I2S-style framing.
  function automatic logic sar_is_left(logic w, sar_fmt_e f);
    return (f == FMT_I2S20) ? !w : w;
  endfunction

  function automatic logic sar_right_aligned(sar_fmt_e f);
    return (f == FMT_RJ16) || (f == FMT_RJ20);
  endfunction

  // Whether the bit at position idx of a half-frame belongs to the word.
  function automatic logic sar_takes_bit(sar_fmt_e f, int unsigned idx,
                                         int unsigned width);
    logic r;
    case (f)
      FMT_RJ16, FMT_RJ20: r = 1'b1;
      FMT_LJ20:           r = (idx < width);
      default:            r = (idx >= 1) && (idx <= width);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sar_sync_edge.sv
module sar_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic wclk_i,
  input  logic sdata_i,
  output logic bclk_rise_o,
  output logic bclk_fall_o,
  output logic wclk_s_o,
  output logic sdata_s_o
);

  localparam int unsigned LAST = STAGES - 1;

  // {bclk, wclk, sdata} travel through the same chain so they stay aligned.
  logic [2:0] sh_q [STAGES];
  logic       bclk_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(STAGES); k++) sh_q[k] <= 3'b000;
      bclk_prev_q <= 1'b0;
    end else begin
      sh_q[0] <= {bclk_i, wclk_i, sdata_i};
      for (int k = 1; k < int'(STAGES); k++) sh_q[k] <= sh_q[k-1];
      bclk_prev_q <= sh_q[LAST][2];
    end
  end

  assign bclk_rise_o = sh_q[LAST][2] & ~bclk_prev_q;
  assign bclk_fall_o = ~sh_q[LAST][2] & bclk_prev_q;
  assign wclk_s_o    = sh_q[LAST][1];
  assign sdata_s_o   = sh_q[LAST][0];

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(bclk_rise_o && bclk_fall_o)) else $error("rise and fall together"); // R3
  AST_RISE_THEN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n) bclk_rise_o |=> !bclk_rise_o) else $error("double rise"); // R2

endmodule

// File: rtl/sar_slot_shift.sv
module sar_slot_shift
  import sar_pkg::*;
#(
  parameter int unsigned WORD_W  = SAR_WORD_W,
  parameter int unsigned SHORT_W = SAR_SHORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              sample_en_i,
  input  logic              wclk_bit_i,
  input  logic              data_bit_i,
  input  sar_fmt_e          fmt_i,
  output logic              commit_o,
  output logic              commit_left_o,
  output logic [WORD_W-1:0] commit_word_o
);

  localparam int unsigned CNT_W   = $clog2(WORD_W + 2) + 1;
  localparam int unsigned EXT_W   = WORD_W - SHORT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic              seen_q, synced_q, w_prev_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] acc_q;
  logic              boundary_w;
  logic              take_w;
  logic              take_first_w;

  // Right-justified short words are widened by copying their sign bit.
  function automatic logic [WORD_W-1:0] form_word(logic [WORD_W-1:0] a,
                                                  sar_fmt_e f);
    logic [WORD_W-1:0] r;
    if (f == FMT_RJ16) r = {{EXT_W{a[SHORT_W-1]}}, a[SHORT_W-1:0]};
    else               r = a;
    return r;
  endfunction

  assign boundary_w   = sample_en_i && seen_q && (wclk_bit_i != w_prev_q);
  assign take_w       = sar_takes_bit(fmt_i, {{(32-CNT_W){1'b0}}, cnt_q}, WORD_W);
  assign take_first_w = sar_takes_bit(fmt_i, 0, WORD_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q        <= 1'b0;
      synced_q      <= 1'b0;
      w_prev_q      <= 1'b0;
      cnt_q         <= '0;
      acc_q         <= '0;
      commit_o      <= 1'b0;
      commit_left_o <= 1'b0;
      commit_word_o <= '0;
    end else begin
      commit_o <= 1'b0;
      if (restart_i) begin
        seen_q   <= 1'b0;
        synced_q <= 1'b0;
        cnt_q    <= '0;
        acc_q    <= '0;
      end else if (sample_en_i) begin
        w_prev_q <= wclk_bit_i;
        seen_q   <= 1'b1;
        if (boundary_w) begin
          if (synced_q) begin
            commit_o      <= 1'b1;
            commit_left_o <= sar_is_left(w_prev_q, fmt_i);
            commit_word_o <= form_word(acc_q, fmt_i);
          end
          synced_q <= 1'b1;
          cnt_q    <= {{(CNT_W-1){1'b0}}, 1'b1};
          acc_q    <= take_first_w ? {{(WORD_W-1){1'b0}}, data_bit_i} : '0;
        end else begin
          if (take_w) acc_q <= {acc_q[WORD_W-2:0], data_bit_i};
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_COMMIT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) commit_o |-> $past(boundary_w)) else $error("commit without boundary"); // R6
  AST_RESTART_BLOCKS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) restart_i |=> !commit_o) else $error("commit after restart"); // R8
  AST_FIRST_HALF_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (boundary_w && !synced_q) |=> !commit_o) else $error("partial half committed"); // R7

endmodule

// File: rtl/sar_frame_pair.sv
module sar_frame_pair #(
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              commit_i,
  input  logic              commit_left_i,
  input  logic [WORD_W-1:0] commit_word_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  logic [WORD_W-1:0] left_hold_q;
  logic              have_left_q;
  logic              pair_done_w;

  assign pair_done_w = commit_i && !commit_left_i && have_left_q && !restart_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (restart_i) begin
        have_left_q <= 1'b0;
      end else if (commit_i && commit_left_i) begin
        left_hold_q <= commit_word_i;
        have_left_q <= 1'b1;
      end else if (pair_done_w) begin
        left_o      <= left_hold_q;
        right_o     <= commit_word_i;
        valid_o     <= 1'b1;
        have_left_q <= 1'b0;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) valid_o |=> !valid_o) else $error("strobe longer than one cycle"); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !valid_o |-> ($stable(left_o) && $stable(right_o))) else $error("outputs moved without strobe"); // R6
  AST_PAIR_NEEDS_LEFT: assert property (@(posedge clk) disable iff (!rst_n) valid_o |-> $past(have_left_q)) else $error("pair without left word"); // R6
  AST_RESTART_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) restart_i |=> !valid_o) else $error("strobe after restart"); // R8

endmodule

// File: rtl/sar_rx.sv
module sar_rx
  import sar_pkg::*;
#(
  parameter int unsigned WORD_W      = SAR_WORD_W,
  parameter int unsigned SHORT_W     = SAR_SHORT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              sdata_i,
  input  logic [1:0]        fmt_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);

  localparam int unsigned EXT_W = WORD_W - SHORT_W;

  sar_fmt_e          fmt_q;
  logic              restart_w;
  logic              rise_w, fall_w, wclk_s_w, sdata_s_w;
  logic              sample_en_w;
  logic              commit_w, commit_left_w;
  logic [WORD_W-1:0] commit_word_w;

  always_ff @(posedge clk) begin
    if (!rst_n) fmt_q <= FMT_RJ16;
    else        fmt_q <= sar_fmt_e'(fmt_i);
  end

  assign restart_w   = (sar_fmt_e'(fmt_i) != fmt_q);
  assign sample_en_w = sar_on_fall(fmt_q) ? fall_w : rise_w;

  sar_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_i      (bclk_i),
    .wclk_i      (wclk_i),
    .sdata_i     (sdata_i),
    .bclk_rise_o (rise_w),
    .bclk_fall_o (fall_w),
    .wclk_s_o    (wclk_s_w),
    .sdata_s_o   (sdata_s_w)
  );

  sar_slot_shift #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .restart_i     (restart_w),
    .sample_en_i   (sample_en_w),
    .wclk_bit_i    (wclk_s_w),
    .data_bit_i    (sdata_s_w),
    .fmt_i         (fmt_q),
    .commit_o      (commit_w),
    .commit_left_o (commit_left_w),
    .commit_word_o (commit_word_w)
  );

  sar_frame_pair #(.WORD_W(WORD_W)) u_pair (
    .clk           (clk),
    .rst_n         (rst_n),
    .restart_i     (restart_w),
    .commit_i      (commit_w),
    .commit_left_i (commit_left_w),
    .commit_word_i (commit_word_w),
    .left_o        (left_o),
    .right_o       (right_o),
    .valid_o       (valid_o)
  );

  AST_RJ16_SIGN_LEFT: assert property (@(posedge clk) disable iff (!rst_n) (valid_o && $past(fmt_q) == FMT_RJ16) |-> (left_o[WORD_W-1:SHORT_W] == {EXT_W{left_o[SHORT_W-1]}})) else $error("left not sign extended"); // R1
  AST_RJ16_SIGN_RIGHT: assert property (@(posedge clk) disable iff (!rst_n) (valid_o && $past(fmt_q) == FMT_RJ16) |-> (right_o[WORD_W-1:SHORT_W] == {EXT_W{right_o[SHORT_W-1]}})) else $error("right not sign extended"); // R1
  AST_EDGE_FOR_FORMAT: assert property (@(posedge clk) disable iff (!rst_n) (sample_en_w && fmt_q == FMT_LJ20) |-> fall_w) else $error("wrong capture edge"); // R3

endmodule

// File: tb/tb_sar_rx.sv
module tb_sar_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [19:0] left_o, right_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  int mon_bad = 0;
  int cap_n = 0;
  logic [19:0] cap_l [0:7];
  logic [19:0] cap_r [0:7];
  logic [19:0] tx_l [0:3];
  logic [19:0] tx_r [0:3];
  logic        prev_valid = 1'b0;
  logic [19:0] prev_l = '0, prev_r = '0;

  always #10 clk = ~clk;

  sar_rx dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .wclk_i(wclk), .sdata_i(sdata),
    .fmt_i(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  // Monitor: strobe width and output hold (R6), capture of reported pairs.
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o && prev_valid) mon_bad++;
      if (!valid_o && (left_o != prev_l || right_o != prev_r)) mon_bad++;
      if (valid_o && cap_n < 8) begin
        cap_l[cap_n] = left_o;
        cap_r[cap_n] = right_o;
        cap_n++;
      end
    end
    prev_valid = valid_o;
    prev_l = left_o;
    prev_r = right_o;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_word(logic [1:0] f, logic [19:0] w);
    return (f == 2'b00) ? {{4{w[15]}}, w[15:0]} : w;
  endfunction

  // Transmitter bit at position k of a 32-bit half-frame; filler bits are 1.
  function automatic logic tx_bit(logic [1:0] f, logic [19:0] w, int k);
    logic b;
    case (f)
      2'b00:   b = (k >= 16) ? w[31-k] : 1'b1;
      2'b01:   b = (k >= 12) ? w[31-k] : 1'b1;
      2'b10:   b = (k < 20) ? w[19-k] : 1'b1;
      default: b = (k >= 1 && k <= 20) ? w[20-k] : 1'b1;
    endcase
    return b;
  endfunction

  function automatic logic left_level(logic [1:0] f);
    return (f == 2'b11) ? 1'b0 : 1'b1;
  endfunction

  task automatic send_half(logic [1:0] f, logic lvl, logic [19:0] w, int nbits);
    logic chg;
    chg = (f == 2'b10);
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      bclk = chg; wclk = lvl; sdata = tx_bit(f, w, k);
      repeat (4) @(negedge clk);
      bclk = ~chg;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic stream(logic [1:0] f, int n, bit preroll);
    if (preroll) send_half(f, ~left_level(f), 20'h0, 32);
    for (int i = 0; i < n; i++) begin
      send_half(f, left_level(f), tx_l[i], 32);
      send_half(f, ~left_level(f), tx_r[i], 32);
    end
    send_half(f, left_level(f), 20'h0, 32);
    repeat (20) @(negedge clk);
  endtask

  task automatic do_reset(logic [1:0] f);
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b0; wclk = 1'b0; sdata = 1'b0; fmt = f;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cap_n = 0;
  endtask

  task automatic verify(string req, logic [1:0] f, int first, int n_exp, int bad0);
    chk({req, " pair count"}, cap_n, n_exp);
    for (int i = 0; i < n_exp && i < cap_n; i++) begin
      chk({req, " left"}, cap_l[i], exp_word(f, tx_l[first + i]));
      chk({req, " right"}, cap_r[i], exp_word(f, tx_r[first + i]));
    end
    chk("R6 strobe/hold violations", mon_bad - bad0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 valid in reset", valid_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 left after reset", left_o, 0);
    chk("R7 right after reset", right_o, 0);
    chk("R7 valid after reset", valid_o, 0);
  endtask

  task automatic t_rj16();
    int b0 = mon_bad;
    do_reset(2'b00);
    tx_l[0] = 20'h38123; tx_r[0] = 20'h01234;
    tx_l[1] = 20'h07FFF; tx_r[1] = 20'hFFFFF;
    tx_l[2] = 20'h00000; tx_r[2] = 20'h08000;
    stream(2'b00, 3, 1'b1);
    verify("R1 rj16 sign extension", 2'b00, 0, 3, b0);
  endtask

  task automatic t_rj20();
    int b0 = mon_bad;
    do_reset(2'b01);
    tx_l[0] = 20'h80001; tx_r[0] = 20'h00002;
    tx_l[1] = 20'h5A5A5; tx_r[1] = 20'hA5A5A;
    stream(2'b01, 2, 1'b1);
    verify("R2 rj20 / R5 polarity", 2'b01, 0, 2, b0);
  endtask

  task automatic t_lj20();
    int b0 = mon_bad;
    do_reset(2'b10);
    tx_l[0] = 20'h12345; tx_r[0] = 20'hFEDCB;
    tx_l[1] = 20'h00001; tx_r[1] = 20'h80000;
    stream(2'b10, 2, 1'b1);
    verify("R3 lj20 / R5 polarity", 2'b10, 0, 2, b0);
  endtask

  task automatic t_i2s();
    int b0 = mon_bad;
    do_reset(2'b11);
    tx_l[0] = 20'hC0FFE; tx_r[0] = 20'h0BEEF;
    tx_l[1] = 20'h00010; tx_r[1] = 20'h7FFFF;
    stream(2'b11, 2, 1'b1);
    verify("R4 i2s", 2'b11, 0, 2, b0);
  endtask

  task automatic t_first_frame();
    int b0 = mon_bad;
    do_reset(2'b01);
    tx_l[0] = 20'h11111; tx_r[0] = 20'h22222;
    tx_l[1] = 20'h33333; tx_r[1] = 20'h44444;
    stream(2'b01, 2, 1'b0);
    verify("R7 first half discarded", 2'b01, 1, 1, b0);
  endtask

  task automatic t_fmt_change();
    int b0 = mon_bad;
    do_reset(2'b10);
    send_half(2'b10, 1'b0, 20'h0, 32);
    send_half(2'b10, 1'b1, 20'h6789A, 32);
    send_half(2'b10, 1'b0, 20'h13579, 10);
    @(negedge clk);
    fmt = 2'b01;
    tx_l[0] = 20'hABCDE; tx_r[0] = 20'h24680;
    tx_l[1] = 20'h0F0F0; tx_r[1] = 20'hF0F0F;
    stream(2'b01, 2, 1'b1);
    verify("R8 format change resync", 2'b01, 0, 2, b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rj16();
    t_rj20();
    t_lj20();
    t_i2s();
    t_first_frame();
    t_fmt_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule